// File: doc/BRIEF.md
# Ownership Filtering Channel Request FIFO

This block sits on the receive side of a slotted backplane. In every clock slot it sees one channel request made of a 14-bit channel index, a parity bit, a null flag, an active-low flow-control line and a station identifier. It keeps a request only when the slot is not null, flow control is not holding it off, and the station identifier belongs to this station. Kept requests enter a 16-entry FIFO. The downstream logic drains the FIFO one request per cell cycle.

The FIFO head is always visible at the output. When nothing is queued, the output shows the all-ones channel with the null flag set. A small host register file holds four things: the station's own identifier, an ownership-mode bit that accepts every station, a scratch control byte, and a forced-channel register. Writing the forced-channel register queues exactly one extra request alongside the backplane traffic.

Parity errors on the channel index are only counted; the request is handled as usual. A request that arrives while the FIFO is full is lost, and an error line reports the loss.

Top module: `own_req_fifo`

## Requirements
- R1: After synchronous reset the FIFO is empty, `out_chan` is 3FFF, `out_null` is 1 and `ovf_err` is 0. Every host register reads 0, including the forced flag.
- R2: A slot with `in_null`=1 is never queued.
- R3: A slot with `in_fc_n`=0 is never queued. 0 is the blocking level.
- R4: With the mode bit at 0, a non-null, unblocked slot is queued only when `in_sid` equals the own-ID register.
- R5: With the mode bit at 1, every non-null, unblocked slot is queued whatever its `in_sid`.
- R6: Queued requests leave in arrival order. The head is removed on a clock edge where `out_take`=1 and the FIFO is not empty. A request accepted at an edge into an empty FIFO is visible right after that edge. An empty FIFO shows `out_chan`=3FFF with `out_null`=1.
- R7: The host registers read back what was written. They are at the following addresses (`host_addr`):
  - Address 0, own ID: bits 7:0 hold the identifier and bit 8 is the mode bit.
  - Address 1, scratch byte: bits 7:0.
  - Address 3: the parity error count, read only.
- R8: A write to address 2 stores the forced channel in bits 13:0 and sets a pending flag, which reads back on bit 15. While the flag is set and no request is held back, the forced channel is queued at the next edge and the flag clears.
- R9: A forced push takes priority over a backplane request accepted at the same edge. That request is held for one cycle and queued at the next edge. Any requests accepted while a held request is draining are also delayed by one cycle each, so arrival order is kept.
- R10: Every non-null slot whose 14 channel bits and `in_par` contain an odd number of ones increments the parity error count by one. That request is otherwise handled normally.
- R11: The FIFO holds 16 entries. A push to a full FIFO with no pop at the same edge is discarded. `ovf_err` is 1 during the cycle after such an edge and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| in_chan | input | 14 | Incoming channel index |
| in_par | input | 1 | Parity bit for in_chan (even over 15 bits) |
| in_null | input | 1 | Slot carries no request |
| in_fc_n | input | 1 | Flow control, 0 blocks the request |
| in_sid | input | 8 | Station identifier of the slot |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| out_take | input | 1 | Downstream removes the head this cycle |
| out_chan | output | 14 | Head channel, 3FFF when empty |
| out_null | output | 1 | 1 when the FIFO is empty |
| ovf_err | output | 1 | A request was lost to a full FIFO |

## Verification
The bench builds the block with its default parameters: a 16-entry FIFO, a 14-bit channel and an 8-bit station identifier. With only 16 entries, overflow is reached in a few cycles by holding `out_take` low, so the loss of the 17th and 18th requests is observed and the drain order is checked afterwards. A forced write placed right before a run of accepted slots exercises the hold-back path, including a held request that keeps draining. A behavioural queue model predicts the head, the null flag, the error line and every register readback.

// File: rtl/ofq_pkg.sv
package ofq_pkg;
    parameter int CHAN_W = 14;
    parameter int ID_W   = 8;
    parameter int REG_W  = 16;
    parameter int CNT_W  = 16;

    typedef enum logic [1:0] {
        RA_OWN   = 2'd0,
        RA_AUX   = 2'd1,
        RA_FORCE = 2'd2,
        RA_PERR  = 2'd3
    } reg_addr_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              par;
        logic              nul;
        logic              fc_n;
        logic [ID_W-1:0]   sid;
    } slot_t;

    function automatic logic parity_bad(input logic [CHAN_W-1:0] c, input logic p);
        return ^{c, p};
    endfunction
endpackage

// File: rtl/orf_filter.sv
module orf_filter
    import ofq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  slot_t            slot,
    input  logic [ID_W-1:0]  own_id,
    input  logic             accept_all,
    output logic             acc,
    output logic [CNT_W-1:0] perr_cnt
);
    logic id_ok;
    logic perr;

    assign id_ok = accept_all || (slot.sid == own_id);
    assign acc   = !slot.nul && slot.fc_n && id_ok;
    assign perr  = !slot.nul && parity_bad(slot.chan, slot.par);

    always_ff @(posedge clk) begin
        if (rst) perr_cnt <= '0;
        else if (perr) perr_cnt <= perr_cnt + 1'b1;
    end

    // R2
    null_reject_chk: assert property (@(posedge clk) disable iff (rst)
        slot.nul |-> !acc);
    // R3
    fc_reject_chk: assert property (@(posedge clk) disable iff (rst)
        !slot.fc_n |-> !acc);
endmodule

// File: rtl/orf_regs.sv
module orf_regs
    import ofq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  perr_cnt,
    input  logic              force_taken,
    output logic [REG_W-1:0]  rdata,
    output logic [ID_W-1:0]   own_id,
    output logic              accept_all,
    output logic [CHAN_W-1:0] fchan,
    output logic              pend
);
    logic [ID_W-1:0] aux;
    reg_addr_t       ra;

    assign ra = reg_addr_t'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_id     <= '0;
            accept_all <= 1'b0;
            aux        <= '0;
            fchan      <= '0;
            pend       <= 1'b0;
        end else begin
            if (we && ra == RA_OWN) begin
                own_id     <= wdata[ID_W-1:0];
                accept_all <= wdata[ID_W];
            end
            if (we && ra == RA_AUX) aux <= wdata[ID_W-1:0];
            if (we && ra == RA_FORCE) begin
                fchan <= wdata[CHAN_W-1:0];
                pend  <= 1'b1;
            end else if (force_taken) begin
                pend  <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (ra)
            RA_OWN:   rdata = REG_W'({accept_all, own_id});
            RA_AUX:   rdata = REG_W'(aux);
            RA_FORCE: rdata = {pend, {(REG_W-CHAN_W-1){1'b0}}, fchan};
            RA_PERR:  rdata = REG_W'(perr_cnt);
            default:  rdata = '0;
        endcase
    end

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (we && ra == RA_FORCE) |=> pend);
endmodule

// File: rtl/orf_merge.sv
module orf_merge
    import ofq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [CHAN_W-1:0] chan,
    input  logic              pend,
    input  logic [CHAN_W-1:0] fchan,
    output logic              push,
    output logic [CHAN_W-1:0] push_chan,
    output logic              force_taken
);
    logic              hv;
    logic [CHAN_W-1:0] hchan;

    assign force_taken = pend && !hv;
    assign push        = force_taken || hv || acc;

    always_comb begin
        if (force_taken)  push_chan = fchan;
        else if (hv)      push_chan = hchan;
        else              push_chan = chan;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hv    <= 1'b0;
            hchan <= '0;
        end else if (force_taken || hv) begin
            hv    <= acc;
            hchan <= chan;
        end else begin
            hv    <= 1'b0;
        end
    end

    // R9
    hold_source_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !hv);
endmodule

// File: rtl/orf_fifo.sv
module orf_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          full, pop_ok, push_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head    = mem[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= push && !push_ok;
            if (push_ok) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (pop_ok) rp <= nxt(rp);
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
        end
    end

    // R11
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && ovf));
endmodule

// File: rtl/own_req_fifo.sv
module own_req_fifo
    import ofq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic              in_par,
    input  logic              in_null,
    input  logic              in_fc_n,
    input  logic [ID_W-1:0]   in_sid,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic              out_take,
    output logic [CHAN_W-1:0] out_chan,
    output logic              out_null,
    output logic              ovf_err
);
    slot_t             slot;
    logic              acc, accept_all, pend, force_taken, push, empty;
    logic [ID_W-1:0]   own_id;
    logic [CNT_W-1:0]  perr_cnt;
    logic [CHAN_W-1:0] fchan, push_chan, head;

    assign slot = '{chan: in_chan, par: in_par, nul: in_null, fc_n: in_fc_n, sid: in_sid};

    orf_filter u_filter (
        .clk(clk), .rst(rst), .slot(slot), .own_id(own_id),
        .accept_all(accept_all), .acc(acc), .perr_cnt(perr_cnt)
    );

    orf_regs u_regs (
        .clk(clk), .rst(rst), .we(host_we), .addr(host_addr),
        .wdata(host_wdata), .perr_cnt(perr_cnt), .force_taken(force_taken),
        .rdata(host_rdata), .own_id(own_id), .accept_all(accept_all),
        .fchan(fchan), .pend(pend)
    );

    orf_merge u_merge (
        .clk(clk), .rst(rst), .acc(acc), .chan(in_chan), .pend(pend),
        .fchan(fchan), .push(push), .push_chan(push_chan),
        .force_taken(force_taken)
    );

    orf_fifo #(.DEPTH(DEPTH), .W(CHAN_W)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .din(push_chan),
        .pop(out_take), .empty(empty), .head(head), .ovf(ovf_err)
    );

    assign out_null = empty;
    assign out_chan = empty ? '1 : head;

    // R6
    empty_null_chk: assert property (@(posedge clk) disable iff (rst)
        (out_null && !push) |=> out_null);
endmodule

// File: tb/own_req_fifo_tb_top.sv
module own_req_fifo_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic        clk = 0, rst = 1;
    logic [13:0] in_chan = 0;
    logic        in_par = 0, in_null = 1, in_fc_n = 1;
    logic [7:0]  in_sid = 0;
    logic        host_we = 0;
    logic [1:0]  host_addr = 0;
    logic [15:0] host_wdata = 0, host_rdata;
    logic        out_take = 1;
    logic [13:0] out_chan;
    logic        out_null, ovf_err;

    own_req_fifo #(.DEPTH(DEPTH)) dut_i (.*);

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    string phase = "R1";

    // reference model state
    int   q[$];
    logic [7:0]  m_own = 0, m_aux = 0;
    logic        m_all = 0, m_pend = 0, m_hv = 0, m_ovf = 0;
    logic [13:0] m_fch = 0, m_hch = 0;
    int          m_perr = 0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_own = 0; m_aux = 0; m_all = 0; m_pend = 0;
            m_hv = 0; m_ovf = 0; m_fch = 0; m_hch = 0; m_perr = 0;
        end else begin
            bit acc, pushb, popb, npend;
            int pv, sz;
            acc = !in_null && in_fc_n && (m_all || in_sid == m_own);
            if (!in_null && ((^in_chan) ^ in_par)) m_perr = (m_perr + 1) % 65536;
            pushb = 1; pv = 0; npend = m_pend;
            if (m_pend && !m_hv) begin
                pv = m_fch; npend = 0; m_hv = acc; m_hch = in_chan;
            end else if (m_hv) begin
                pv = m_hch; m_hv = acc; m_hch = in_chan;
            end else if (acc) pv = in_chan;
            else pushb = 0;
            sz = q.size();
            popb = out_take && sz > 0;
            if (popb) void'(q.pop_front());
            m_ovf = 0;
            if (pushb) begin
                if (sz < DEPTH || popb) q.push_back(pv);
                else m_ovf = 1;
            end
            if (host_we) begin
                case (host_addr)
                    2'd0: begin m_own = host_wdata[7:0]; m_all = host_wdata[8]; end
                    2'd1: m_aux = host_wdata[7:0];
                    2'd2: begin m_fch = host_wdata[13:0]; npend = 1; end
                    default: ;
                endcase
            end
            m_pend = npend;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk({phase, " out_null"}, out_null, q.size() == 0);
            chk({phase, " out_chan"}, out_chan, q.size() == 0 ? 14'h3FFF : q[0]);
            chk({phase, " ovf_err R11"}, ovf_err, m_ovf);
        end
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog R1: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic slot(input logic [13:0] c, input bit n, input bit f,
                        input logic [7:0] s, input bit bad);
        @(negedge clk);
        host_we = 0; in_chan = c; in_null = n; in_fc_n = f; in_sid = s;
        in_par = (^c) ^ bad;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) slot(14'h0, 1, 1, 8'h0, 0);
    endtask

    task automatic hwr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        in_null = 1; host_we = 1; host_addr = a; host_wdata = d;
    endtask

    task automatic hrd(input logic [1:0] a, input string tag);
        int exp;
        @(negedge clk);
        host_we = 0; in_null = 1; host_addr = a;
        #1;
        case (a)
            2'd0: exp = {m_all, m_own};
            2'd1: exp = m_aux;
            2'd2: exp = {m_pend, 1'b0, m_fch};
            default: exp = m_perr;
        endcase
        chk(tag, host_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        phase = "R1";
        hrd(0, "R1 own reset"); hrd(1, "R1 aux reset");
        hrd(2, "R1 force reset"); hrd(3, "R1 perr reset");
        chk("R1 empty head", out_chan, 14'h3FFF);

        phase = "R7";
        hwr(0, 16'h0014); hwr(1, 16'h0001);
        hrd(0, "R7 own readback"); hrd(1, "R7 aux readback");

        phase = "R4";
        slot(14'h1500, 0, 1, 8'h14, 0);
        slot(14'h1501, 0, 1, 8'h34, 0);
        slot(14'h1502, 0, 1, 8'h16, 0);
        slot(14'h1503, 0, 1, 8'h14, 0);
        phase = "R2";
        slot(14'h1504, 1, 1, 8'h14, 0);
        phase = "R3";
        slot(14'h1505, 0, 0, 8'h14, 0);
        slot(14'h1506, 0, 1, 8'h14, 0);
        idle(3);

        phase = "R5";
        hwr(0, 16'h0114);
        slot(14'h0A00, 0, 1, 8'hFF, 0);
        slot(14'h0A01, 0, 1, 8'h00, 0);
        slot(14'h0A02, 0, 0, 8'h14, 0);
        slot(14'h0A03, 1, 1, 8'h77, 0);
        idle(2);
        hwr(0, 16'h0014);

        phase = "R8";
        hwr(2, 16'h02AA);
        hrd(2, "R8 flag set");
        hrd(2, "R8 flag cleared");
        idle(2);

        phase = "R9";
        hwr(2, 16'h0155);
        slot(14'h1600, 0, 1, 8'h14, 0);
        slot(14'h1601, 0, 1, 8'h14, 0);
        slot(14'h1602, 0, 1, 8'h14, 0);
        idle(1);
        slot(14'h1603, 0, 1, 8'h14, 0);
        idle(4);

        phase = "R10";
        slot(14'h0123, 0, 1, 8'h14, 1);
        slot(14'h0124, 0, 1, 8'h99, 1);
        slot(14'h0125, 1, 1, 8'h14, 1);
        slot(14'h0126, 0, 1, 8'h14, 0);
        idle(2);
        hrd(3, "R10 parity count");
        chk("R10 parity count value", m_perr, 2);

        phase = "R11";
        @(negedge clk); out_take = 0;
        for (int i = 0; i < DEPTH + 2; i++) slot(14'h2000 + 14'(i), 0, 1, 8'h14, 0);
        idle(2);
        chk("R11 queue capped", q.size(), DEPTH);
        @(negedge clk); out_take = 1;
        idle(DEPTH + 3);

        phase = "R6";
        slot(14'h3001, 0, 1, 8'h14, 0);
        slot(14'h3002, 0, 1, 8'h14, 0);
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule